// File: doc/BRIEF.md
# Power-Rail Startup Sequencer

This block is a synchronous controller that turns on the regulator groups of a multi-rail power device in a fixed order, and turns them off again in reverse. A master enable, passed through a two-flop synchronizer, starts the run. The first step powers the two internal logic supplies. The next steps bring up, in turn, a group of three auxiliary LDOs, the two controller buck rails and the two array-supply LDOs. The machine waits for every power-good input of a group before it enables the next group. Once the array-supply LDOs are good, the active-low reset to the external controller is released.

After reset release, nothing more starts on its own. A host command can start an optional general-purpose buck. A second host command starts the high-voltage array regulator, which is always the last rail to come up. If a group's power-good inputs are not all high within a programmable number of clock cycles, or if the master enable falls, the machine removes every enable in reverse order, with a fixed gap between groups. It asserts the controller reset before it turns any rail off. After a timeout it parks in a fault state, and it sets a sticky fault flag that only a host clear command can reset.

Top module: `rail_seq_top`

## Requirements
- R1: While rst is high, and afterwards while the synchronized master enable stays low, every enable output is 0, ctrl_rst_n is 0, fault_flag is 0 and state_code is 0 (idle).
- R2: The logic-supply enables rise on the third rising clock edge after master_en goes high. Two of these edges are spent in the synchronizer.
- R3: The logic-supply group is enabled first (state_code 1). The auxiliary LDO group stays off until every logic-supply power-good is high, and then turns on with state_code 2.
- R4: The controller bucks turn on only after all auxiliary power-goods are high (state_code 3). The array-supply LDOs turn on only after both controller-buck power-goods are high (state_code 4).
- R5: ctrl_rst_n goes high only after both array-supply power-goods are high, and the machine then reports ready (state_code 5).
- R6: The general-purpose buck never starts by itself. A cmd_gp_start pulse starts it only in the ready state (state_code 6 while waiting for its power-good). The command is ignored in every earlier state.
- R7: A cmd_hv_start pulse in the ready state turns on the high-voltage regulator (state_code 7). When its power-good is high the state becomes run (state_code 8). If both commands arrive in the same cycle while the buck is off, the buck start wins and the high-voltage command is dropped.
- R8: If the power-good inputs of the group being waited on are not all high when the cycle counter reaches timeout_cycles, the machine leaves the wait state for shutdown (state_code 9) and marks a fault.
- R9: On a fall of master_en or on a fault, ctrl_rst_n falls first. Enabled groups then turn off one at a time, the most recently enabled first, each OFF_GAP cycles after the previous event (default 4).
- R10: fault_flag becomes 1 on a timeout and holds until a cmd_fault_clr pulse. When a timeout and a clear fall in the same cycle, the set wins.
- R11: After a fault shutdown the machine stays in the fault state (state_code 10) with all rails off, even with master_en high. It returns to idle only once the synchronized master enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Asynchronous master enable |
| pg_logic | input | N_LOGIC | Power-good of the internal logic supplies |
| pg_aux | input | N_AUX | Power-good of the auxiliary LDOs |
| pg_ctl | input | N_CTL | Power-good of the controller bucks |
| pg_arr | input | N_ARR | Power-good of the array-supply LDOs |
| pg_gp | input | 1 | Power-good of the general-purpose buck |
| pg_hv | input | 1 | Power-good of the high-voltage regulator |
| timeout_cycles | input | TMR_W | Power-good wait limit in clock cycles |
| cmd_gp_start | input | 1 | Host pulse: start the general-purpose buck |
| cmd_hv_start | input | 1 | Host pulse: start the high-voltage regulator |
| cmd_fault_clr | input | 1 | Host pulse: clear the sticky fault flag |
| en_logic | output | N_LOGIC | Enables of the logic supplies |
| en_aux | output | N_AUX | Enables of the auxiliary LDOs |
| en_ctl | output | N_CTL | Enables of the controller bucks |
| en_arr | output | N_ARR | Enables of the array-supply LDOs |
| en_gp | output | 1 | Enable of the general-purpose buck |
| en_hv | output | 1 | Enable of the high-voltage regulator |
| ctrl_rst_n | output | 1 | Active-low reset to the controller |
| state_code | output | 4 | Current state encoding |
| fault_flag | output | 1 | Sticky fault flag |

## Verification
Two pairs of events can land on the same clock edge. The bench forces both. For the first pair, it pulses the buck-start and high-voltage-start commands in the same ready cycle. It then checks that only the buck enable rises, and that the high-voltage enable stays low after the buck reports good. For the second pair, it holds the fault-clear command high for a whole run in which a group never reports good, so that the timeout edge and a clear coincide. It then checks that the fault flag is seen high for exactly one sampled cycle.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  localparam int GRP_N   = 6;
  localparam int G_LOGIC = 0;
  localparam int G_AUX   = 1;
  localparam int G_CTL   = 2;
  localparam int G_ARR   = 3;
  localparam int G_GP    = 4;
  localparam int G_HV    = 5;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_UP_LOGIC = 4'd1,
    ST_UP_AUX   = 4'd2,
    ST_UP_CTL   = 4'd3,
    ST_UP_ARR   = 4'd4,
    ST_READY    = 4'd5,
    ST_UP_GP    = 4'd6,
    ST_UP_HV    = 4'd7,
    ST_RUN      = 4'd8,
    ST_SHUT     = 4'd9,
    ST_FAULT    = 4'd10
  } seq_state_e;

  // Clears the highest set bit: the group enabled most recently goes first.
  function automatic logic [GRP_N-1:0] drop_top(input logic [GRP_N-1:0] m);
    logic [GRP_N-1:0] r;
    logic             done;
    r    = m;
    done = 1'b0;
    for (int i = GRP_N - 1; i >= 0; i--) begin
      if (!done && m[i]) begin
        r[i] = 1'b0;
        done = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/rail_sync.sv
module rail_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rail_grp_good.sv
module rail_grp_good #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pg,
  output logic         good
);
  always_ff @(posedge clk) begin
    if (rst) good <= 1'b0;
    else     good <= &pg;
  end
endmodule

// File: rtl/rail_cycle_timer.sv
module rail_cycle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)    cnt <= '0;
    else if (cnt != '1) cnt <= cnt + 1'b1;
  end

  // R8: the wait counter advances by one each cycle it is not cleared
  assert_timer_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt != '1) |=> (cnt == $past(cnt) + 1'b1))
    else $error("timer did not advance");
endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
  import rail_seq_pkg::*;
#(
  parameter int N_LOGIC     = 2,
  parameter int N_AUX       = 3,
  parameter int N_CTL       = 2,
  parameter int N_ARR       = 2,
  parameter int TMR_W       = 16,
  parameter int OFF_GAP     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               master_en,
  input  logic [N_LOGIC-1:0] pg_logic,
  input  logic [N_AUX-1:0]   pg_aux,
  input  logic [N_CTL-1:0]   pg_ctl,
  input  logic [N_ARR-1:0]   pg_arr,
  input  logic               pg_gp,
  input  logic               pg_hv,
  input  logic [TMR_W-1:0]   timeout_cycles,
  input  logic               cmd_gp_start,
  input  logic               cmd_hv_start,
  input  logic               cmd_fault_clr,
  output logic [N_LOGIC-1:0] en_logic,
  output logic [N_AUX-1:0]   en_aux,
  output logic [N_CTL-1:0]   en_ctl,
  output logic [N_ARR-1:0]   en_arr,
  output logic               en_gp,
  output logic               en_hv,
  output logic               ctrl_rst_n,
  output logic [3:0]         state_code,
  output logic               fault_flag
);
  localparam int GAP_W = $clog2(OFF_GAP + 1);

  logic             en_s;
  logic [GRP_N-1:0] grp_good;
  seq_state_e       state_q, state_d;
  logic [GRP_N-1:0] on_q, on_d;
  logic             pend_q, pend_d;
  logic             rst_n_q, rst_n_d;
  logic             fault_q, fault_evt;
  logic [TMR_W-1:0] step_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic             step_clr, gap_clr, step_to, gap_hit;
  logic             is_up, has_next;
  logic [2:0]       cur_g, nxt_g;
  seq_state_e       nxt_st;

  // ---------------- master enable synchronizer ----------------
  rail_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(master_en), .q(en_s)
  );

  // ---------------- per-group power-good reduction ----------------
  rail_grp_good #(.W(N_LOGIC)) u_pg_logic (.clk(clk), .rst(rst), .pg(pg_logic), .good(grp_good[G_LOGIC]));
  rail_grp_good #(.W(N_AUX))   u_pg_aux   (.clk(clk), .rst(rst), .pg(pg_aux),   .good(grp_good[G_AUX]));
  rail_grp_good #(.W(N_CTL))   u_pg_ctl   (.clk(clk), .rst(rst), .pg(pg_ctl),   .good(grp_good[G_CTL]));
  rail_grp_good #(.W(N_ARR))   u_pg_arr   (.clk(clk), .rst(rst), .pg(pg_arr),   .good(grp_good[G_ARR]));
  rail_grp_good #(.W(1))       u_pg_gp    (.clk(clk), .rst(rst), .pg(pg_gp),    .good(grp_good[G_GP]));
  rail_grp_good #(.W(1))       u_pg_hv    (.clk(clk), .rst(rst), .pg(pg_hv),    .good(grp_good[G_HV]));

  // ---------------- timers ----------------
  rail_cycle_timer #(.W(TMR_W)) u_step_tmr (
    .clk(clk), .rst(rst), .clr(step_clr), .cnt(step_cnt)
  );
  rail_cycle_timer #(.W(GAP_W)) u_gap_tmr (
    .clk(clk), .rst(rst), .clr(gap_clr), .cnt(gap_cnt)
  );

  assign step_to  = (step_cnt >= timeout_cycles);
  assign gap_hit  = (gap_cnt == GAP_W'(OFF_GAP - 1));
  assign step_clr = (state_d != state_q);
  assign gap_clr  = (state_q != ST_SHUT) || gap_hit;

  // ---------------- next-state logic ----------------
  always_comb begin
    state_d   = state_q;
    on_d      = on_q;
    pend_d    = pend_q;
    fault_evt = 1'b0;
    is_up     = 1'b0;
    has_next  = 1'b0;
    cur_g     = 3'(G_LOGIC);
    nxt_g     = 3'(G_LOGIC);
    nxt_st    = ST_IDLE;

    unique case (state_q)
      ST_IDLE: begin
        if (en_s) begin
          state_d        = ST_UP_LOGIC;
          on_d[G_LOGIC]  = 1'b1;
          pend_d         = 1'b0;
        end
      end
      ST_UP_LOGIC: begin
        is_up = 1'b1; cur_g = 3'(G_LOGIC); nxt_st = ST_UP_AUX;
        has_next = 1'b1; nxt_g = 3'(G_AUX);
      end
      ST_UP_AUX: begin
        is_up = 1'b1; cur_g = 3'(G_AUX); nxt_st = ST_UP_CTL;
        has_next = 1'b1; nxt_g = 3'(G_CTL);
      end
      ST_UP_CTL: begin
        is_up = 1'b1; cur_g = 3'(G_CTL); nxt_st = ST_UP_ARR;
        has_next = 1'b1; nxt_g = 3'(G_ARR);
      end
      ST_UP_ARR: begin
        is_up = 1'b1; cur_g = 3'(G_ARR); nxt_st = ST_READY;
      end
      ST_UP_GP: begin
        is_up = 1'b1; cur_g = 3'(G_GP); nxt_st = ST_READY;
      end
      ST_UP_HV: begin
        is_up = 1'b1; cur_g = 3'(G_HV); nxt_st = ST_RUN;
      end
      ST_READY: begin
        if (!en_s) begin
          state_d = ST_SHUT;
        end else if (cmd_gp_start && !on_q[G_GP]) begin
          state_d     = ST_UP_GP;
          on_d[G_GP]  = 1'b1;
        end else if (cmd_hv_start) begin
          state_d     = ST_UP_HV;
          on_d[G_HV]  = 1'b1;
        end
      end
      ST_RUN: begin
        if (!en_s) state_d = ST_SHUT;
      end
      ST_SHUT: begin
        if (on_q == '0)   state_d = pend_q ? ST_FAULT : ST_IDLE;
        else if (gap_hit) on_d    = drop_top(on_q);
      end
      ST_FAULT: begin
        if (!en_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    if (is_up) begin
      if (!en_s) begin
        state_d = ST_SHUT;
      end else if (grp_good[cur_g]) begin
        state_d = nxt_st;
        if (has_next) on_d[nxt_g] = 1'b1;
      end else if (step_to) begin
        state_d   = ST_SHUT;
        pend_d    = 1'b1;
        fault_evt = 1'b1;
      end
    end
  end

  assign rst_n_d = (state_d == ST_READY) || (state_d == ST_UP_GP) ||
                   (state_d == ST_UP_HV) || (state_d == ST_RUN);

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      on_q    <= '0;
      pend_q  <= 1'b0;
      rst_n_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      on_q    <= on_d;
      pend_q  <= pend_d;
      rst_n_q <= rst_n_d;
      if (fault_evt)          fault_q <= 1'b1;
      else if (cmd_fault_clr) fault_q <= 1'b0;
    end
  end

  assign en_logic   = {N_LOGIC{on_q[G_LOGIC]}};
  assign en_aux     = {N_AUX{on_q[G_AUX]}};
  assign en_ctl     = {N_CTL{on_q[G_CTL]}};
  assign en_arr     = {N_ARR{on_q[G_ARR]}};
  assign en_gp      = on_q[G_GP];
  assign en_hv      = on_q[G_HV];
  assign ctrl_rst_n = rst_n_q;
  assign state_code = state_q;
  assign fault_flag = fault_q;

  // ---------------- assertions ----------------
  assert_start_sync_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(on_q[G_LOGIC]) |-> $past(en_s))
    else $error("logic rails started without synchronized enable");

  assert_aux_after_logic_R3: assert property (@(posedge clk) disable iff (rst)
    on_q[G_AUX] |-> on_q[G_LOGIC])
    else $error("aux group on without logic group");

  assert_chain_order_R4: assert property (@(posedge clk) disable iff (rst)
    (on_q[G_CTL] |-> on_q[G_AUX]) and (on_q[G_ARR] |-> on_q[G_CTL]))
    else $error("controller/array group order broken");

  assert_rst_needs_arr_R5: assert property (@(posedge clk) disable iff (rst)
    rst_n_q |-> (on_q[G_ARR:G_LOGIC] == 4'hF))
    else $error("controller reset released early");

  assert_gp_after_rst_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(on_q[G_GP]) |-> $past(rst_n_q))
    else $error("general-purpose buck started before reset release");

  assert_hv_last_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(on_q[G_HV]) |-> ($past(rst_n_q) && on_q[G_ARR:G_LOGIC] == 4'hF))
    else $error("high-voltage regulator not last");

  assert_rst_before_off_R9: assert property (@(posedge clk) disable iff (rst)
    (($past(on_q) & ~on_q) != '0) |-> (!rst_n_q && !$past(rst_n_q)))
    else $error("rail turned off while reset released");

  assert_fault_sets_R10: assert property (@(posedge clk) disable iff (rst)
    fault_evt |=> fault_q)
    else $error("fault flag not set");

  assert_fault_parked_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FAULT) |-> (on_q == '0 && !rst_n_q))
    else $error("fault state with rail on");
endmodule

// File: tb/tb_rail_seq_top.sv
module tb_rail_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 4;
  localparam int TMO        = 20;

  // step table: [7:5] group to report good, [4] expected ctrl_rst_n, [3:0] expected state
  localparam logic [7:0] STEPS [4] = '{
    {3'd0, 1'b0, 4'd2},
    {3'd1, 1'b0, 4'd3},
    {3'd2, 1'b0, 4'd4},
    {3'd3, 1'b1, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        master_en = 1'b0;
  logic [1:0]  pg_logic = '0;
  logic [2:0]  pg_aux = '0;
  logic [1:0]  pg_ctl = '0;
  logic [1:0]  pg_arr = '0;
  logic        pg_gp = 1'b0;
  logic        pg_hv = 1'b0;
  logic [15:0] tmo = 16'(TMO);
  logic        cmd_gp_start = 1'b0;
  logic        cmd_hv_start = 1'b0;
  logic        cmd_fault_clr = 1'b0;
  logic [1:0]  en_logic;
  logic [2:0]  en_aux;
  logic [1:0]  en_ctl;
  logic [1:0]  en_arr;
  logic        en_gp, en_hv, ctrl_rst_n, fault_flag;
  logic [3:0]  state_code;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc;
  int hits;
  logic [7:0] ent;
  logic [5:0] v, prev, cur;

  rail_seq_top dut (
    .clk(clk), .rst(rst), .master_en(master_en),
    .pg_logic(pg_logic), .pg_aux(pg_aux), .pg_ctl(pg_ctl), .pg_arr(pg_arr),
    .pg_gp(pg_gp), .pg_hv(pg_hv), .timeout_cycles(tmo),
    .cmd_gp_start(cmd_gp_start), .cmd_hv_start(cmd_hv_start), .cmd_fault_clr(cmd_fault_clr),
    .en_logic(en_logic), .en_aux(en_aux), .en_ctl(en_ctl), .en_arr(en_arr),
    .en_gp(en_gp), .en_hv(en_hv), .ctrl_rst_n(ctrl_rst_n),
    .state_code(state_code), .fault_flag(fault_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] view();
    return {en_hv, en_gp, &en_arr, &en_ctl, &en_aux, &en_logic};
  endfunction

  function automatic logic [5:0] top_bit(input logic [5:0] m);
    for (int i = 5; i >= 0; i--) if (m[i]) return 6'(1) << i;
    return 6'd0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input logic [3:0] code, input int maxc);
    for (int i = 0; i < maxc && state_code != code; i++) @(negedge clk);
  endtask

  task automatic set_pg(input int g, input logic val);
    case (g)
      0: pg_logic = {2{val}};
      1: pg_aux   = {3{val}};
      2: pg_ctl   = {2{val}};
      3: pg_arr   = {2{val}};
      4: pg_gp    = val;
      default: pg_hv = val;
    endcase
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    // ---- R1: reset state and idle with enable low ----
    cycles(4);
    chk("R1 reset state_code", int'(state_code), 0);
    chk("R1 reset enables", int'(view()), 0);
    chk("R1 reset ctrl_rst_n", int'(ctrl_rst_n), 0);
    chk("R1 reset fault_flag", int'(fault_flag), 0);
    rst = 1'b0;
    cycles(10);
    chk("R1 idle without enable", int'(state_code), 0);
    chk("R1 no rail without enable", int'(view()), 0);

    // ---- R2: synchronizer latency ----
    master_en = 1'b1;
    cmd_gp_start = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    cmd_gp_start = 1'b0;
    chk("R2 logic off after two edges", int'(en_logic), 0);
    @(negedge clk);
    chk("R2 logic on at third edge", int'(en_logic), 3);
    chk("R3 state up-logic", int'(state_code), 1);
    cmd_gp_start = 1'b1;
    @(negedge clk);
    cmd_gp_start = 1'b0;
    chk("R6 buck command ignored before reset release", int'(en_gp), 0);

    // ---- R3/R4/R5: table walk of the automatic steps ----
    for (int s = 0; s < 4; s++) begin
      ent = STEPS[s];
      cycles(3);
      v = view();
      chk($sformatf("R3 step %0d group on", s), int'(v[ent[7:5]]), 1);
      if (ent[7:5] < 3'd3)
        chk($sformatf("R4 step %0d next group waits", s), int'(v[ent[7:5] + 3'd1]), 0);
      chk($sformatf("R5 step %0d reset held", s), int'(ctrl_rst_n), 0);
      set_pg(int'(ent[7:5]), 1'b1);
      wait_state(ent[3:0], 10);
      chk($sformatf("R4 step %0d state", s), int'(state_code), int'(ent[3:0]));
      chk($sformatf("R5 step %0d ctrl_rst_n", s), int'(ctrl_rst_n), int'(ent[4]));
    end
    cycles(5);
    chk("R6 buck not automatic", int'(en_gp), 0);
    chk("R7 hv not automatic", int'(en_hv), 0);
    chk("R5 still ready", int'(state_code), 5);

    // ---- R7: both commands in one cycle, buck wins ----
    cmd_gp_start = 1'b1;
    cmd_hv_start = 1'b1;
    @(negedge clk);
    cmd_gp_start = 1'b0;
    cmd_hv_start = 1'b0;
    chk("R6 buck start state", int'(state_code), 6);
    chk("R6 buck enabled", int'(en_gp), 1);
    chk("R7 hv dropped on collision", int'(en_hv), 0);
    pg_gp = 1'b1;
    wait_state(4'd5, 10);
    chk("R6 back to ready", int'(state_code), 5);
    chk("R7 hv still off after collision", int'(en_hv), 0);
    cmd_hv_start = 1'b1;
    @(negedge clk);
    cmd_hv_start = 1'b0;
    chk("R7 hv start state", int'(state_code), 7);
    chk("R7 hv enabled", int'(en_hv), 1);
    pg_hv = 1'b1;
    wait_state(4'd8, 10);
    chk("R7 run state", int'(state_code), 8);

    // ---- R9: ordered shutdown on enable drop ----
    master_en = 1'b0;
    for (int i = 0; i < 10 && ctrl_rst_n; i++) @(negedge clk);
    chk("R9 reset asserted", int'(ctrl_rst_n), 0);
    chk("R9 all rails on when reset falls", int'(view()), 63);
    prev = view();
    cyc  = 0;
    for (int i = 0; i < 100 && prev != 6'd0; i++) begin
      @(negedge clk);
      cyc++;
      cur = view();
      if (cur != prev) begin
        chk("R9 most recent group off first", int'(prev & ~cur), int'(top_bit(prev)));
        chk("R9 gap between groups", cyc, GAP);
        cyc  = 0;
        prev = cur;
      end
    end
    chk("R9 all rails off", int'(view()), 0);
    for (int g = 0; g < 6; g++) set_pg(g, 1'b0);
    wait_state(4'd0, 10);
    chk("R9 idle after shutdown", int'(state_code), 0);
    chk("R10 no fault on normal shutdown", int'(fault_flag), 0);

    // ---- R8/R10/R11: timeout fault ----
    master_en = 1'b1;
    for (int i = 0; i < 10 && en_logic == 2'b00; i++) @(negedge clk);
    cyc = 0;
    for (int i = 0; i < 60 && state_code != 4'd9; i++) begin
      @(negedge clk);
      cyc++;
    end
    chk_rng("R8 timeout latency", cyc, TMO, TMO + 2);
    chk("R8 shutdown on timeout", int'(state_code), 9);
    chk("R10 fault flag set", int'(fault_flag), 1);
    wait_state(4'd10, 20);
    chk("R11 fault state", int'(state_code), 10);
    chk("R11 rails off in fault", int'(view()), 0);
    cycles(20);
    chk("R11 no restart while enabled", int'(state_code), 10);
    chk("R10 fault sticky", int'(fault_flag), 1);
    cmd_fault_clr = 1'b1;
    @(negedge clk);
    cmd_fault_clr = 1'b0;
    chk("R10 fault cleared", int'(fault_flag), 0);
    master_en = 1'b0;
    wait_state(4'd0, 10);
    chk("R11 idle after enable low", int'(state_code), 0);

    // ---- R10: set and clear in the same cycle ----
    cmd_fault_clr = 1'b1;
    master_en = 1'b1;
    hits = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (fault_flag) hits++;
    end
    chk("R10 set wins over clear", hits, 1);
    chk("R11 fault state after coincident clear", int'(state_code), 10);
    cmd_fault_clr = 1'b0;
    master_en = 1'b0;
    wait_state(4'd0, 10);
    chk("R11 idle again", int'(state_code), 0);

    finish_up();
  end
endmodule